// File: doc/BRIEF.md
# Phase-Shift Full-Bridge Gate Generator

This block drives the four gate lines of an H-bridge inverter. A free-running counter on the system clock marks out a control period, and the bridge switches at half the counter's wrap rate. The right-hand leg (upper switch G3, lower switch G4) changes over on every period wrap. The left-hand leg (upper G1, lower G2) changes over on every match between the counter and a phase compare value. The compare value alone sets how far the left leg lags the right leg, and so sets the effective pulse width seen by the load. The largest compare value (period minus one) gives a half-period lag, where G1 conducts with G4 and G2 with G3.

Every changeover in a leg has the same three steps. The switch that is on turns off. Both switches then stay off for a programmed dead count. After that the other switch turns on. Both directions of the changeover take the same number of cycles, so upper and lower pulses have the same width.

Period, phase compare and dead count come in as plain configuration inputs. They are captured only at a period wrap. The captured phase is clamped into the window from the dead count to the period minus one. A dead count of zero is raised to one. Correct operation needs a period of at least twice the effective dead count plus two.

Top module: `bridge_phase_pwm`

## Requirements
- R1: While reset is active all four gates are low. After reset, G4 is the first gate to rise, at the first period wrap. G2 rises next, phase+1 cycles after G4, at the first phase match following that wrap. G1 and G3 stay low until both of those rises have happened.
- R2: Once the configuration is steady, every gate repeats with a period of exactly 2·P clock cycles, where P is the captured period value.
- R3: The right leg changes over when the counter wraps (count P−1). The left leg changes over when the count equals the captured phase value ph. A rise of G1 therefore follows the preceding rise of G3 by ph+1 cycles.
- R4: At every changeover both switches of the leg stay low for exactly D cycles, where D is the captured dead count. A dead input of 0 acts as D = 1.
- R5: In steady operation the upper and lower gates of each leg are each high for exactly P−D cycles per bridge period.
- R6: The upper and lower gate of the same leg are never high in the same cycle.
- R7: A change to period, phase or dead input during a period has no effect on that period's phase match. The change applies from the next wrap onward.
- R8: The phase value is clamped to the range [D, P−1]. A phase below D behaves as D, so the G3-to-G1 delay is D+1. A phase above P−1 behaves as P−1, so the delay is P.
- R9: With the phase at P−1 (full load), G1 and G4 rise in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| period_i | input | CW | Control period in clock cycles (P) |
| phase_i | input | CW | Phase compare value, the count at which the left leg changes over |
| dead_i | input | DW | Dead gap in clock cycles |
| gate_a_hi_o | output | 1 | Left leg upper gate (G1) |
| gate_a_lo_o | output | 1 | Left leg lower gate (G2) |
| gate_b_hi_o | output | 1 | Right leg upper gate (G3) |
| gate_b_lo_o | output | 1 | Right leg lower gate (G4) |

## Verification
The bench builds the block with an 8-bit counter, a 4-bit dead count and reset defaults of period 16, phase 7 and dead 2. Periods this short make a full sweep affordable: for periods of 12, 16 and 24 and dead inputs 0 to 3, every phase value from 0 to P+1 is applied. That range covers both clamp edges and the full-load point. For each setting the bench measures the leg delay, the pulse widths, the dead gaps and the repeat period. Separate runs cover the start-up order after reset and a phase change made in the middle of a period.

// File: rtl/bpp_pkg.sv
package bpp_pkg;

  // leg sequencer state
  typedef enum logic {
    LEG_HOLD = 1'b0,
    LEG_GAP  = 1'b1
  } leg_st_e;

  // leg indices in the event and gate vectors
  localparam int unsigned NUM_LEGS = 2;
  localparam int unsigned LEG_A    = 0;  // changes over on phase match
  localparam int unsigned LEG_B    = 1;  // changes over on period wrap

endpackage

// File: rtl/bpp_timebase.sv
module bpp_timebase #(
  parameter int unsigned CW          = 16,
  parameter int unsigned DW          = 8,
  parameter int unsigned DEF_PERIOD  = 400,
  parameter int unsigned DEF_PHASE   = 399,
  parameter int unsigned DEF_DEAD    = 13
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [CW-1:0]                period_i,
  input  logic [CW-1:0]                phase_i,
  input  logic [DW-1:0]                dead_i,
  output logic [bpp_pkg::NUM_LEGS-1:0] evt_o,
  output logic [DW-1:0]                dead_o
);

  localparam logic [CW-1:0] PER_RST  = CW'(DEF_PERIOD);
  localparam logic [CW-1:0] PH_RST   = CW'(DEF_PHASE);
  localparam logic [DW-1:0] DEAD_RST = DW'(DEF_DEAD);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] per_q, per_d;
  logic [CW-1:0] ph_q, ph_d;
  logic [DW-1:0] dead_q, dead_d;
  logic          armed_q, armed_d;
  logic          wrap;
  logic          match;

  // candidate shadow values, clamped before capture
  logic [DW-1:0] dead_new;
  logic [CW-1:0] ph_lo, ph_hi, ph_new;

  always_comb begin
    dead_new = (dead_i == '0) ? DW'(1) : dead_i;
    ph_lo    = CW'(dead_new);
    ph_hi    = period_i - CW'(1);
    if (phase_i < ph_lo)      ph_new = ph_lo;
    else if (phase_i > ph_hi) ph_new = ph_hi;
    else                      ph_new = phase_i;
  end

  always_comb begin
    wrap      = (cnt_q == per_q - CW'(1));
    match     = armed_q && (cnt_q == ph_q);
    cnt_d     = wrap ? '0 : cnt_q + CW'(1);
    per_d     = per_q;
    ph_d      = ph_q;
    dead_d    = dead_q;
    armed_d   = armed_q;
    if (wrap) begin
      per_d   = period_i;
      ph_d    = ph_new;
      dead_d  = dead_new;
      armed_d = 1'b1;
    end
  end

  // counter, always enabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // shadow configuration, enabled on wrap only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q   <= PER_RST;
      ph_q    <= PH_RST;
      dead_q  <= DEAD_RST;
      armed_q <= 1'b0;
    end else if (wrap) begin
      per_q   <= per_d;
      ph_q    <= ph_d;
      dead_q  <= dead_d;
      armed_q <= armed_d;
    end
  end

  assign evt_o[bpp_pkg::LEG_A] = match;
  assign evt_o[bpp_pkg::LEG_B] = wrap;
  assign dead_o                = dead_q;

endmodule

// File: rtl/bpp_leg.sv
module bpp_leg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          toggle_i,
  input  logic [DW-1:0] dead_i,
  output logic          hi_o,
  output logic          lo_o
);

  import bpp_pkg::*;

  leg_st_e       st_q, st_d;
  logic          side_q, side_d;  // 1: upper selected, 0: lower selected
  logic [DW-1:0] gap_q, gap_d;
  logic          hi_q, hi_d;
  logic          lo_q, lo_d;
  logic          en;

  always_comb begin
    st_d   = st_q;
    side_d = side_q;
    gap_d  = gap_q;
    hi_d   = hi_q;
    lo_d   = lo_q;
    if (toggle_i) begin
      // turn-off step: both low, select the other switch, start the gap
      hi_d   = 1'b0;
      lo_d   = 1'b0;
      side_d = ~side_q;
      gap_d  = dead_i;
      st_d   = LEG_GAP;
    end else if (st_q == LEG_GAP) begin
      if (gap_q <= DW'(1)) begin
        // turn-on step, same length for either side
        hi_d  = side_q;
        lo_d  = ~side_q;
        gap_d = '0;
        st_d  = LEG_HOLD;
      end else begin
        gap_d = gap_q - DW'(1);
      end
    end
  end

  assign en = toggle_i || (st_q == LEG_GAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LEG_HOLD;
      side_q <= 1'b1;  // first changeover selects the lower switch
      gap_q  <= '0;
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
    end else if (en) begin
      st_q   <= st_d;
      side_q <= side_d;
      gap_q  <= gap_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

endmodule

// File: rtl/bridge_phase_pwm.sv
module bridge_phase_pwm #(
  parameter int unsigned CW         = 16,
  parameter int unsigned DW         = 8,
  parameter int unsigned DEF_PERIOD = 400,
  parameter int unsigned DEF_PHASE  = 399,
  parameter int unsigned DEF_DEAD   = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] period_i,
  input  logic [CW-1:0] phase_i,
  input  logic [DW-1:0] dead_i,
  output logic          gate_a_hi_o,
  output logic          gate_a_lo_o,
  output logic          gate_b_hi_o,
  output logic          gate_b_lo_o
);

  import bpp_pkg::*;

  logic                rst_q1;
  logic                rst_int_n;
  logic [NUM_LEGS-1:0] leg_evt;
  logic [NUM_LEGS-1:0] leg_hi;
  logic [NUM_LEGS-1:0] leg_lo;
  logic [DW-1:0]       dead_eff;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1    <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_q1    <= 1'b1;
      rst_int_n <= rst_q1;
    end
  end

  bpp_timebase #(
    .CW         (CW),
    .DW         (DW),
    .DEF_PERIOD (DEF_PERIOD),
    .DEF_PHASE  (DEF_PHASE),
    .DEF_DEAD   (DEF_DEAD)
  ) i_timebase (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .period_i (period_i),
    .phase_i  (phase_i),
    .dead_i   (dead_i),
    .evt_o    (leg_evt),
    .dead_o   (dead_eff)
  );

  for (genvar l = 0; l < NUM_LEGS; l++) begin : g_leg
    bpp_leg #(
      .DW (DW)
    ) i_leg (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .toggle_i (leg_evt[l]),
      .dead_i   (dead_eff),
      .hi_o     (leg_hi[l]),
      .lo_o     (leg_lo[l])
    );
  end

  assign gate_a_hi_o = leg_hi[LEG_A];
  assign gate_a_lo_o = leg_lo[LEG_A];
  assign gate_b_hi_o = leg_hi[LEG_B];
  assign gate_b_lo_o = leg_lo[LEG_B];

endmodule

// File: rtl/bpp_checker.sv
module bpp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       a_hi,
  input logic       a_lo,
  input logic       b_hi,
  input logic       b_lo,
  input logic [1:0] evt
);

  // R1
  rst_low_chk: assert property (@(posedge clk)
    !rst_n |-> !(a_hi || a_lo || b_hi || b_lo));

  // R6
  a_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_hi && a_lo));

  // R6
  b_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(b_hi && b_lo));

  // R4
  a_hi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_hi) |-> !$past(a_lo));

  // R4
  a_lo_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_lo) |-> !$past(a_hi));

  // R4
  b_hi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b_hi) |-> !$past(b_lo));

  // R4
  b_lo_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b_lo) |-> !$past(b_hi));

  // R3
  a_off_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(a_hi) || $fell(a_lo)) |-> $past(evt[0]));

  // R3
  b_off_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(b_hi) || $fell(b_lo)) |-> $past(evt[1]));

endmodule

bind bridge_phase_pwm bpp_checker i_bpp_chk (
  .clk  (clk),
  .rst_n(rst_int_n),
  .a_hi (gate_a_hi_o),
  .a_lo (gate_a_lo_o),
  .b_hi (gate_b_hi_o),
  .b_lo (gate_b_lo_o),
  .evt  (leg_evt)
);

// File: tb/test_bridge_phase_pwm.sv
`timescale 1ns/1ps
module test_bridge_phase_pwm;

  localparam int CW = 8;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] period_i;
  logic [CW-1:0] phase_i;
  logic [DW-1:0] dead_i;
  logic          g_a_hi, g_a_lo, g_b_hi, g_b_lo;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int ovl = 0;
  bit done = 1'b0;
  bit run_on = 1'b0;
  int rise_n[4] = '{0, 0, 0, 0};
  int fall_n[4] = '{0, 0, 0, 0};
  int rise_t[4] = '{0, 0, 0, 0};
  int fall_t[4] = '{0, 0, 0, 0};
  logic [3:0] g, g_prev = 4'b0;

  always #5 clk = ~clk;

  bridge_phase_pwm #(
    .CW(CW), .DW(DW), .DEF_PERIOD(16), .DEF_PHASE(7), .DEF_DEAD(2)
  ) i_bridge_phase_pwm (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .phase_i(phase_i),
    .dead_i(dead_i), .gate_a_hi_o(g_a_hi), .gate_a_lo_o(g_a_lo),
    .gate_b_hi_o(g_b_hi), .gate_b_lo_o(g_b_lo)
  );

  // index 0: G1, 1: G2, 2: G3, 3: G4
  assign g = {g_b_lo, g_b_hi, g_a_lo, g_a_hi};

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (g[i] && !g_prev[i]) begin rise_n[i]++; rise_t[i] = cyc; end
      if (!g[i] && g_prev[i]) begin fall_n[i]++; fall_t[i] = cyc; end
    end
    if (run_on && ((g[0] && g[1]) || (g[2] && g[3]))) ovl++;
    g_prev = g;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_rise(input int idx, output int t);
    int c0;
    c0 = rise_n[idx];
    while (rise_n[idx] == c0) @(posedge clk);
    t = rise_t[idx];
  endtask

  task automatic wait_fall(input int idx, output int t);
    int c0;
    c0 = fall_n[idx];
    while (fall_n[idx] == c0) @(posedge clk);
    t = fall_t[idx];
  endtask

  task automatic run_case(input int p, input int ph, input int d);
    int de, pe, t0, t1, t2, t3, t4, t5;
    @(negedge clk);
    period_i = CW'(p);
    phase_i  = CW'(ph);
    dead_i   = DW'(d);
    repeat (4 * p + 4) @(posedge clk);
    de = (d == 0) ? 1 : d;
    pe = (ph < de) ? de : ((ph > p - 1) ? p - 1 : ph);
    wait_rise(2, t0);
    wait_rise(0, t1);
    if (ph != pe) chk("R8 clamped G3->G1 delay", t1 - t0, pe + 1);
    else          chk("R3 G3->G1 delay", t1 - t0, pe + 1);
    if (pe == p - 1) chk("R9 G4 rise cycle vs G1", rise_t[3], t1);
    wait_fall(0, t2);
    chk("R5 G1 width", t2 - t1, p - de);
    wait_rise(1, t3);
    chk("R4 dead gap G1->G2", t3 - t2, de);
    wait_fall(1, t4);
    chk("R5 G2 width", t4 - t3, p - de);
    wait_rise(0, t5);
    chk("R2 G1 repeat period", t5 - t1, 2 * p);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int t0, t1, p;
    rst_n    = 1'b0;
    period_i = CW'(16);
    phase_i  = CW'(7);
    dead_i   = DW'(2);
    repeat (3) @(negedge clk);
    chk("R1 gates during reset", int'(g), 0);
    rst_n  = 1'b1;
    run_on = 1'b1;
    // R1 start-up order
    wait_rise(3, t0);
    chk("R1 gates up before G4", rise_n[0] + rise_n[1] + rise_n[2], 0);
    wait_rise(1, t1);
    chk("R1 G4->G2 delay", t1 - t0, 8);
    chk("R1 G1/G3 still low at G2 rise", rise_n[0] + rise_n[2], 0);

    // sweep: R2 R3 R4 R5 R8 R9
    for (int pi = 0; pi < 3; pi++) begin
      p = (pi == 0) ? 12 : ((pi == 1) ? 16 : 24);
      for (int d = 0; d < 4; d++) begin
        for (int ph = 0; ph <= p + 1; ph++) run_case(p, ph, d);
      end
    end

    // R7: phase change mid-period applies at the next wrap
    run_case(16, 4, 2);
    wait_rise(2, t0);
    @(negedge clk);
    phase_i = CW'(11);
    wait_rise(0, t1);
    chk("R7 delay in current period", t1 - t0, 5);
    wait_rise(2, t0);
    wait_rise(0, t1);
    chk("R7 delay after wrap", t1 - t0, 12);

    chk("R6 cycles with both gates of a leg high", ovl, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule